// File: doc/BRIEF.md
# Descriptor condition and command-pointer unit

This block makes the per-descriptor decisions in a descriptor-driven DMA channel. It reads three 2-bit condition modes from the current command word: one for waiting, one for branching and one for raising an interrupt. Each mode is tested against a masked compare of the low device-status bits. Each condition has its own select word, which supplies the compare mask and the compare value.

The wait flag and the interrupt pulse are combinational on the current inputs. When the channel sequencer has written back a descriptor, it pulses a single-cycle commit strobe. On that strobe the registered command pointer either jumps to the descriptor's command-dependent word, with the branch-taken flag set, or moves on by one descriptor, with the flag cleared. A separate load strobe sets the starting pointer, rounded down to a descriptor boundary. The sequencer samples the interrupt pulse before the pointer moves, so the interrupt decision comes ahead of the branch decision.

Top module: `desc_cond_unit`

## Requirements
- R1: The command word carries three 2-bit mode fields: the wait mode in bits 1:0, the branch mode in bits 3:2 and the interrupt mode in bits 5:4. Each mode is encoded as 0 = never, 1 = when the condition is true, 2 = when the condition is false, 3 = always.
- R2: A select word holds a 4-bit compare mask in bits 19:16 and a 4-bit compare value in bits 3:0. Its condition is true when (status[3:0] & mask) == (value & mask). Status bits 7:4 have no effect.
- R3: wait_o is the wait mode resolved against the wait select word. It is combinational and does not depend on commit_i.
- R4: irq_o is high exactly in a cycle where commit_i is high, wait_o is low and the interrupt mode, resolved against the interrupt select word, fires.
- R5: A commit whose branch mode fires loads cmd_ptr_o from cmd_dep_i and sets br_taken_o in the next cycle.
- R6: A commit whose branch mode does not fire adds 16 to cmd_ptr_o, wrapping modulo 2^32, and clears br_taken_o in the next cycle.
- R7: A commit while wait_o is high is ignored. irq_o stays low, and cmd_ptr_o and br_taken_o are unchanged.
- R8: ptr_load_i loads ptr_load_val_i with bits 3:0 cleared and clears br_taken_o. It takes priority over a commit in the same cycle.
- R9: After reset, cmd_ptr_o is 0 and br_taken_o is 0.
- R10: A select word with a zero mask gives a condition that is always true. Mode 1 then always fires and mode 2 never fires.
- R11: In a cycle with neither a commit nor a load, cmd_ptr_o and br_taken_o hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_word_i | input | 16 | Command word of the current descriptor |
| dev_status_i | input | 8 | Device status bits |
| int_sel_i | input | 32 | Interrupt select word (mask 19:16, value 3:0) |
| br_sel_i | input | 32 | Branch select word (mask 19:16, value 3:0) |
| wait_sel_i | input | 32 | Wait select word (mask 19:16, value 3:0) |
| cmd_dep_i | input | 32 | Command-dependent word, used as the branch target |
| commit_i | input | 1 | Single-cycle commit strobe from the sequencer |
| ptr_load_i | input | 1 | Load strobe for the starting pointer |
| ptr_load_val_i | input | 32 | Starting pointer value |
| wait_o | output | 1 | The descriptor must wait |
| irq_o | output | 1 | Interrupt pulse |
| cmd_ptr_o | output | 32 | Registered command pointer |
| br_taken_o | output | 1 | The last pointer update was a branch |

## Verification
The bench builds the unit with its default parameters: a 32-bit pointer, 16-byte descriptors, an 8-bit status and a 4-bit compare. These values let the pointer reach the top of the 32-bit address space, where the 16-byte step wraps to zero. They also give a full four-bit masked compare, so the bench can set the ignored upper status bits and try masks from zero to all ones. The bench also drives a load and a commit in the same cycle, and a commit while a wait holds, to check the priority and suppression rules.

// File: rtl/dcu_pkg.sv
`timescale 1ns/1ps
package dcu_pkg;
  typedef enum logic [1:0] {
    COND_NEVER    = 2'd0,
    COND_IF_TRUE  = 2'd1,
    COND_IF_FALSE = 2'd2,
    COND_ALWAYS   = 2'd3
  } cond_mode_e;

  // Condition slots; the mode field of slot k sits at bits 2k+1:2k
  localparam int unsigned SLOT_WAIT = 0;
  localparam int unsigned SLOT_BR   = 1;
  localparam int unsigned SLOT_INT  = 2;
  localparam int unsigned NUM_SLOTS = 3;
  localparam int unsigned MODE_W    = 2;

  function automatic logic resolve_mode(cond_mode_e mode, logic hit);
    unique case (mode)
      COND_NEVER:    return 1'b0;
      COND_IF_TRUE:  return hit;
      COND_IF_FALSE: return ~hit;
      default:       return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/dcu_cond_eval.sv
`timescale 1ns/1ps
module dcu_cond_eval
  import dcu_pkg::*;
#(
  parameter int unsigned STAT_W   = 8,
  parameter int unsigned SEL_W    = 32,
  parameter int unsigned CMP_W    = 4,
  parameter int unsigned MASK_LSB = 16
) (
  input  cond_mode_e        mode_i,
  input  logic [STAT_W-1:0] status_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic              hit_o,
  output logic              fire_o
);
  logic [CMP_W-1:0] cmp_mask, cmp_val, diff;

  always_comb begin
    cmp_mask = sel_i[MASK_LSB +: CMP_W];
    cmp_val  = sel_i[CMP_W-1:0];
    diff     = (status_i[CMP_W-1:0] ^ cmp_val) & cmp_mask;
    hit_o    = (diff == '0);
    fire_o   = resolve_mode(mode_i, hit_o);
  end
endmodule

// File: rtl/dcu_ptr_reg.sv
`timescale 1ns/1ps
module dcu_ptr_reg #(
  parameter int unsigned PTR_W      = 32,
  parameter int unsigned DESC_BYTES = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [PTR_W-1:0] load_val_i,
  input  logic             commit_i,
  input  logic             take_i,
  input  logic [PTR_W-1:0] target_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic             bt_o
);
  localparam int unsigned ALIGN_W = $clog2(DESC_BYTES);
  localparam logic [PTR_W-1:0] STEP = PTR_W'(DESC_BYTES);

  logic [PTR_W-1:0] ptr_q;
  logic             bt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      bt_q  <= 1'b0;
    end else if (load_i) begin
      ptr_q <= {load_val_i[PTR_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
      bt_q  <= 1'b0;
    end else if (commit_i) begin
      if (take_i) begin
        ptr_q <= target_i;
        bt_q  <= 1'b1;
      end else begin
        ptr_q <= ptr_q + STEP;
        bt_q  <= 1'b0;
      end
    end
  end

  assign ptr_o = ptr_q;
  assign bt_o  = bt_q;
endmodule

// File: rtl/desc_cond_unit.sv
`timescale 1ns/1ps
module desc_cond_unit
  import dcu_pkg::*;
#(
  parameter int unsigned PTR_W      = 32,
  parameter int unsigned CMD_W      = 16,
  parameter int unsigned STAT_W     = 8,
  parameter int unsigned SEL_W      = 32,
  parameter int unsigned CMP_W      = 4,
  parameter int unsigned MASK_LSB   = 16,
  parameter int unsigned DESC_BYTES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CMD_W-1:0]  cmd_word_i,
  input  logic [STAT_W-1:0] dev_status_i,
  input  logic [SEL_W-1:0]  int_sel_i,
  input  logic [SEL_W-1:0]  br_sel_i,
  input  logic [SEL_W-1:0]  wait_sel_i,
  input  logic [PTR_W-1:0]  cmd_dep_i,
  input  logic              commit_i,
  input  logic              ptr_load_i,
  input  logic [PTR_W-1:0]  ptr_load_val_i,
  output logic              wait_o,
  output logic              irq_o,
  output logic [PTR_W-1:0]  cmd_ptr_o,
  output logic              br_taken_o
);
  logic [NUM_SLOTS-1:0][SEL_W-1:0] sel_arr;
  logic [NUM_SLOTS-1:0]            hit, fire;
  logic                            commit_eff;

  assign sel_arr[SLOT_WAIT] = wait_sel_i;
  assign sel_arr[SLOT_BR]   = br_sel_i;
  assign sel_arr[SLOT_INT]  = int_sel_i;

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    dcu_cond_eval #(
      .STAT_W  (STAT_W),
      .SEL_W   (SEL_W),
      .CMP_W   (CMP_W),
      .MASK_LSB(MASK_LSB)
    ) u_eval (
      .mode_i  (cond_mode_e'(cmd_word_i[MODE_W*k +: MODE_W])),
      .status_i(dev_status_i),
      .sel_i   (sel_arr[k]),
      .hit_o   (hit[k]),
      .fire_o  (fire[k])
    );
  end

  // a waiting descriptor does not retire
  assign commit_eff = commit_i & ~fire[SLOT_WAIT];
  assign wait_o     = fire[SLOT_WAIT];
  assign irq_o      = commit_eff & fire[SLOT_INT];

  dcu_ptr_reg #(
    .PTR_W     (PTR_W),
    .DESC_BYTES(DESC_BYTES)
  ) u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (ptr_load_i),
    .load_val_i(ptr_load_val_i),
    .commit_i  (commit_eff),
    .take_i    (fire[SLOT_BR]),
    .target_i  (cmd_dep_i),
    .ptr_o     (cmd_ptr_o),
    .bt_o      (br_taken_o)
  );

  logic unused_hit;
  assign unused_hit = ^hit;
endmodule

// File: rtl/dcu_checker.sv
`timescale 1ns/1ps
module dcu_checker #(
  parameter int unsigned PTR_W      = 32,
  parameter int unsigned CMD_W      = 16,
  parameter int unsigned DESC_BYTES = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CMD_W-1:0] cmd_word_i,
  input logic [PTR_W-1:0] cmd_dep_i,
  input logic             commit_i,
  input logic             ptr_load_i,
  input logic             wait_o,
  input logic             irq_o,
  input logic [PTR_W-1:0] cmd_ptr_o,
  input logic             br_taken_o
);
  localparam int unsigned ALIGN_W = $clog2(DESC_BYTES);
  logic retire;
  assign retire = commit_i && !wait_o && !ptr_load_i;

  assert_wait_never_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_word_i[1:0] == 2'd0 |-> !wait_o);
  assert_wait_always_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_word_i[1:0] == 2'd3 |-> wait_o);
  assert_irq_in_commit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> commit_i && !wait_o);
  assert_irq_always_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && !wait_o && cmd_word_i[5:4] == 2'd3 |-> irq_o);
  assert_irq_never_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_word_i[5:4] == 2'd0 |-> !irq_o);
  assert_branch_target_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire && cmd_word_i[3:2] == 2'd3 |=> br_taken_o && cmd_ptr_o == $past(cmd_dep_i));
  assert_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire && cmd_word_i[3:2] == 2'd0 |=>
      !br_taken_o && cmd_ptr_o == $past(cmd_ptr_o) + PTR_W'(DESC_BYTES));
  assert_wait_blocks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_o && !ptr_load_i |=> $stable(cmd_ptr_o) && $stable(br_taken_o));
  assert_load_aligned_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_load_i |=> !br_taken_o && cmd_ptr_o[ALIGN_W-1:0] == '0);
  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i && !ptr_load_i |=> $stable(cmd_ptr_o) && $stable(br_taken_o));
endmodule

bind desc_cond_unit dcu_checker #(
  .PTR_W     (PTR_W),
  .CMD_W     (CMD_W),
  .DESC_BYTES(DESC_BYTES)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cmd_word_i(cmd_word_i),
  .cmd_dep_i (cmd_dep_i),
  .commit_i  (commit_i),
  .ptr_load_i(ptr_load_i),
  .wait_o    (wait_o),
  .irq_o     (irq_o),
  .cmd_ptr_o (cmd_ptr_o),
  .br_taken_o(br_taken_o)
);

// File: tb/sim_desc_cond_unit.sv
`timescale 1ns/1ps
module sim_desc_cond_unit;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] cmd_word = '0;
  logic [7:0]  status = '0;
  logic [31:0] int_sel = '0, br_sel = '0, wait_sel = '0, dep = '0, ld_val = '0;
  logic        commit = 1'b0, ld = 1'b0;
  logic        wait_o, irq_o, bt_o;
  logic [31:0] ptr_o;

  int checks = 0;
  int failures = 0;

  typedef struct packed {
    logic        w;
    logic        irq;
    logic [31:0] ptr;
    logic        bt;
  } exp_t;
  exp_t  exp_q[$];
  string tag_q[$];

  logic [31:0] m_ptr = '0;
  logic        m_bt = 1'b0;

  always #10 clk = ~clk;

  desc_cond_unit u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_word_i(cmd_word), .dev_status_i(status),
    .int_sel_i(int_sel), .br_sel_i(br_sel), .wait_sel_i(wait_sel), .cmd_dep_i(dep),
    .commit_i(commit), .ptr_load_i(ld), .ptr_load_val_i(ld_val),
    .wait_o(wait_o), .irq_o(irq_o), .cmd_ptr_o(ptr_o), .br_taken_o(bt_o)
  );

  function automatic logic cond_hit(logic [31:0] sel, logic [7:0] st);
    return ((st[3:0] & sel[19:16]) == (sel[3:0] & sel[19:16]));
  endfunction

  function automatic logic mode_fire(logic [1:0] m, logic h);
    case (m)
      2'd0: return 1'b0;
      2'd1: return h;
      2'd2: return !h;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [31:0] sel_word(logic [3:0] mask, logic [3:0] val);
    return {12'h000, mask, 12'h000, val};
  endfunction

  function automatic logic [15:0] modes(logic [1:0] im, logic [1:0] bm, logic [1:0] wm);
    return {10'd0, im, bm, wm};
  endfunction

  task automatic step(input logic [15:0] cw, input logic [7:0] st,
                      input logic [31:0] is, input logic [31:0] bs, input logic [31:0] ws,
                      input logic [31:0] dp, input logic cm, input logic l,
                      input logic [31:0] lv, input string tag);
    exp_t e;
    logic wf, bf, inf;
    @(negedge clk);
    cmd_word = cw; status = st; int_sel = is; br_sel = bs; wait_sel = ws;
    dep = dp; commit = cm; ld = l; ld_val = lv;
    wf  = mode_fire(cw[1:0], cond_hit(ws, st));
    bf  = mode_fire(cw[3:2], cond_hit(bs, st));
    inf = mode_fire(cw[5:4], cond_hit(is, st));
    e.w = wf; e.irq = cm && !wf && inf; e.ptr = m_ptr; e.bt = m_bt;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    if (l) begin
      m_ptr = {lv[31:4], 4'h0}; m_bt = 1'b0;
    end else if (cm && !wf) begin
      if (bf) begin m_ptr = dp; m_bt = 1'b1; end
      else begin m_ptr = m_ptr + 32'd16; m_bt = 1'b0; end
    end
  endtask

  task automatic idle(input string tag);
    step(16'h0, 8'h0, '0, '0, '0, '0, 1'b0, 1'b0, '0, tag);
  endtask

  task automatic cmp(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  // monitor: sample mid low phase, before the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (exp_q.size() > 0) begin
        exp_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        cmp(t, "wait", {31'd0, wait_o}, {31'd0, e.w});
        cmp(t, "irq",  {31'd0, irq_o},  {31'd0, e.irq});
        cmp(t, "ptr",  ptr_o, e.ptr);
        cmp(t, "bt",   {31'd0, bt_o},   {31'd0, e.bt});
      end
    end
  end

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    idle("R9 reset");
    // R8 load aligns
    step(16'h0, 8'h0, '0, '0, '0, '0, 1'b0, 1'b1, 32'h1234_567F, "R8 load");
    // R6 step, R4 no irq with modes never
    step(modes(2'd0, 2'd0, 2'd0), 8'h0, '0, '0, '0, 32'hDEAD_0000, 1'b1, 1'b0, '0, "R6 step");
    // R5 branch always
    step(modes(2'd0, 2'd3, 2'd0), 8'h0, '0, '0, '0, 32'hABCD_0040, 1'b1, 1'b0, '0, "R5 branch");
    // R6 clears bt
    step(modes(2'd0, 2'd0, 2'd0), 8'h0, '0, '0, '0, '0, 1'b1, 1'b0, '0, "R6 clear bt");
    // R2/R4 if-true, match, upper status ignored
    step(modes(2'd1, 2'd0, 2'd0), 8'hF5, sel_word(4'hF, 4'h5), '0, '0, '0, 1'b1, 1'b0, '0, "R2 upper ignored");
    step(modes(2'd1, 2'd0, 2'd0), 8'h04, sel_word(4'hF, 4'h5), '0, '0, '0, 1'b1, 1'b0, '0, "R4 if-true miss");
    step(modes(2'd2, 2'd0, 2'd0), 8'h04, sel_word(4'hF, 4'h5), '0, '0, '0, 1'b1, 1'b0, '0, "R4 if-false");
    // R2 partial mask: only bit 2 compared
    step(modes(2'd0, 2'd1, 2'd0), 8'h07, '0, sel_word(4'h4, 4'hC), '0, 32'h0000_0A00, 1'b1, 1'b0, '0, "R2 partial mask");
    step(modes(2'd0, 2'd1, 2'd0), 8'h03, '0, sel_word(4'h4, 4'hC), '0, 32'h0000_0B00, 1'b1, 1'b0, '0, "R2 mask miss");
    // R3 wait without commit; R7 commit during wait ignored
    step(modes(2'd3, 2'd3, 2'd3), 8'h0, '0, '0, '0, 32'h5555_5550, 1'b0, 1'b0, '0, "R3 wait idle");
    step(modes(2'd3, 2'd3, 2'd3), 8'h0, '0, '0, '0, 32'h5555_5550, 1'b1, 1'b0, '0, "R7 commit in wait");
    idle("R7 unchanged");
    // R3/R1 wait if-true on a failing condition, if-false on passing one
    step(modes(2'd0, 2'd0, 2'd1), 8'h01, '0, '0, sel_word(4'h1, 4'h0), '0, 1'b1, 1'b0, '0, "R3 wait if-true miss");
    step(modes(2'd0, 2'd0, 2'd2), 8'h01, '0, '0, sel_word(4'h1, 4'h1), '0, 1'b1, 1'b0, '0, "R1 wait if-false hit");
    // R10 zero mask
    step(modes(2'd1, 2'd1, 2'd2), 8'h0A, '0, sel_word(4'h0, 4'h5), sel_word(4'h0, 4'h3), 32'h0000_7000, 1'b1, 1'b0, '0, "R10 mode1 always");
    step(modes(2'd2, 2'd2, 2'd1), 8'h0A, '0, sel_word(4'h0, 4'h5), sel_word(4'h0, 4'h3), 32'h0000_8000, 1'b1, 1'b0, '0, "R10 mode2 never");
    // R8 load beats commit
    step(modes(2'd0, 2'd3, 2'd0), 8'h0, '0, '0, '0, 32'h1111_1110, 1'b1, 1'b1, 32'hFFFF_FFF9, "R8 load priority");
    // R6 wrap
    step(modes(2'd0, 2'd0, 2'd0), 8'h0, '0, '0, '0, '0, 1'b1, 1'b0, '0, "R6 wrap");
    idle("R11 hold");
    idle("R11 hold again");
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule